// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs trap entry for a core with three privilege levels: machine (M), supervisor (S) and user (U). On a single-cycle trap strobe it takes the trap class, the cause code, the current privilege, the current status word, the faulting PC and the trap value. It chooses the level that handles the trap from the delegation masks. It then updates that level's cause, exception-PC and trap-value registers, rewrites the status word and the privilege, and redirects fetch to the handler address.

The delegation masks and the vector registers are supplied by the surrounding CSR file. The block owns the registered result of trap entry. That result is the new privilege, the rewritten status word, the per-level cause/EPC/TVAL registers, the NMI-enable bit and the redirect PC. Non-maskable interrupts always go to M and use their own vector. Interrupts may be vectored. Every entry also sends a one-cycle pulse to clear a load reservation. A synchronous reset puts the core in M at a fixed start address.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst` is high, at each clock edge: privilege becomes M (3), the whole status word becomes 0 (so MIE and MPRV are clear), all cause/EPC/TVAL registers become 0, NMI-enable becomes 1, `redirect_pc` becomes `RESET_VEC`, and `redirect_valid`/`resv_clear` become 0.
- R2: A trap of class 2 (non-maskable interrupt) is always handled in M. It takes its handler base from `nmi_tvec` and clears NMI-enable.
- R3: An interrupt (class 1) taken from S or U goes to S when bit `code` of `m_ideleg` is set. It goes on to U when, in addition, the current privilege is U and bit `code` of `s_ideleg` is set. Otherwise it goes to M.
- R4: An exception (class 0) follows the same two-stage rule as R3, using `m_edeleg` and `s_edeleg`.
- R5: A trap taken while in M (privilege 3) is handled in M whatever the delegation masks hold.
- R6: The status word uses these bit positions: UIE 0, SIE 1, MIE 3, UPIE 4, SPIE 5, MPIE 7, SPP 8, MPP 12:11, MPRV 17. On entry to M, MPP takes the old privilege, MPIE takes MIE and MIE clears. On entry to S, SPP takes bit 0 of the old privilege, SPIE takes SIE and SIE clears. On entry to U, UPIE takes UIE and UIE clears. All other bits keep their input values.
- R7: The target level's cause register receives the code in its low `CODE_W` bits and zero above them. Bit XLEN-1 is set for classes 1 and 2 and clear for class 0.
- R8: The target level's EPC receives `cur_pc` and its TVAL receives `trap_value`. The registers of the other two levels keep their values.
- R9: The handler PC is the selected vector with bits 1:0 forced to 0. The selected vector is `u_tvec`, `s_tvec`, `m_tvec`, or `nmi_tvec` for class 2. When the vector's bits 1:0 equal 1 and the class is 1 or 2, 4 × code is added.
- R10: All results of a trap strobe appear together on the next clock edge. `redirect_valid` and `resv_clear` are high for exactly that one cycle per strobe. Without a strobe, no output changes.
- R11: When `rst` and `trap_valid` are high in the same cycle, reset wins and the trap leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_class | input | 2 | 0 exception, 1 interrupt, 2 non-maskable interrupt |
| trap_code | input | CODE_W | Cause code |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_pc | input | XLEN | Address of the trapping instruction |
| trap_value | input | XLEN | Trap value for TVAL |
| cur_status | input | STAT_W | Current status word |
| m_ideleg | input | XLEN | Machine interrupt-delegation mask |
| m_edeleg | input | XLEN | Machine exception-delegation mask |
| s_ideleg | input | XLEN | Supervisor interrupt-delegation mask |
| s_edeleg | input | XLEN | Supervisor exception-delegation mask |
| m_tvec | input | XLEN | M-level trap vector |
| s_tvec | input | XLEN | S-level trap vector |
| u_tvec | input | XLEN | U-level trap vector |
| nmi_tvec | input | XLEN | Non-maskable interrupt vector |
| priv_q | output | 2 | Privilege after entry |
| status_q | output | STAT_W | Status word after entry |
| nmi_en_q | output | 1 | NMI enable |
| m_cause | output | XLEN | M cause register |
| m_epc | output | XLEN | M exception PC |
| m_tval | output | XLEN | M trap value |
| s_cause | output | XLEN | S cause register |
| s_epc | output | XLEN | S exception PC |
| s_tval | output | XLEN | S trap value |
| u_cause | output | XLEN | U cause register |
| u_epc | output | XLEN | U exception PC |
| u_tval | output | XLEN | U trap value |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | XLEN | Handler PC (start address after reset) |
| resv_clear | output | 1 | One-cycle load-reservation clear |

## Verification
Two events can share a cycle here: a reset and a trap strobe. The bench raises both in the same cycle and expects every output to show the reset values, with no redirect pulse and with the non-target registers still cleared. A second overlap is a non-maskable interrupt that arrives while an M handler is running with MIE already clear. The bench strobes it immediately after an M-level trap and checks that the M cause, EPC and status fields are overwritten with the new entry. The reference model recomputes every output each cycle, so a stale or blended value from either overlap shows up as a mismatch.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        TC_EXC  = 2'd0,
        TC_IRQ  = 2'd1,
        TC_NMI  = 2'd2,
        TC_RSVD = 2'd3
    } trap_class_e;

    localparam int STAT_W  = 18;
    localparam int NUM_LVL = 3;
    localparam int LVL_W   = 2;

    // Status word, bit positions fixed because neighbouring logic decodes them.
    typedef struct packed {
        logic       mprv;     // 17
        logic [3:0] rsv_hi;   // 16:13
        logic [1:0] mpp;      // 12:11
        logic [1:0] rsv_mid;  // 10:9
        logic       spp;      // 8
        logic       mpie;     // 7
        logic       rsv_b6;   // 6
        logic       spie;     // 5
        logic       upie;     // 4
        logic       mie;      // 3
        logic       rsv_b2;   // 2
        logic       sie;      // 1
        logic       uie;      // 0
    } status_t;

    function automatic logic class_is_irq(trap_class_e c);
        return c != TC_EXC;
    endfunction

    function automatic logic [LVL_W-1:0] lvl_of(priv_e p);
        logic [LVL_W-1:0] l;
        case (p)
            PRIV_M:  l = LVL_W'(2);
            PRIV_S:  l = LVL_W'(1);
            default: l = LVL_W'(0);
        endcase
        return l;
    endfunction

    function automatic status_t enter_status(status_t s, priv_e tgt, priv_e prev);
        status_t r;
        r = s;
        case (tgt)
            PRIV_M: begin
                r.mpp  = prev;
                r.mpie = s.mie;
                r.mie  = 1'b0;
            end
            PRIV_S: begin
                r.spp  = prev[0];
                r.spie = s.sie;
                r.sie  = 1'b0;
            end
            default: begin
                r.upie = s.uie;
                r.uie  = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  trap_class_e       cls,
    input  logic [CODE_W-1:0] code,
    input  priv_e             cur,
    input  logic [XLEN-1:0]   m_ideleg,
    input  logic [XLEN-1:0]   m_edeleg,
    input  logic [XLEN-1:0]   s_ideleg,
    input  logic [XLEN-1:0]   s_edeleg,
    output priv_e             tgt
);
    logic            irq;
    logic [XLEN-1:0] m_mask;
    logic [XLEN-1:0] s_mask;
    logic            to_s;
    logic            to_u;

    always_comb begin
        irq    = class_is_irq(cls);
        m_mask = irq ? m_ideleg : m_edeleg;
        s_mask = irq ? s_ideleg : s_edeleg;
        // first stage: out of M into S, never from M itself
        to_s   = (cur != PRIV_M) && m_mask[code];
        // second stage: only from U and only after the first stage fired
        to_u   = to_s && (cur == PRIV_U) && s_mask[code];
        if (cls == TC_NMI)
            tgt = PRIV_M;
        else if (to_u)
            tgt = PRIV_U;
        else if (to_s)
            tgt = PRIV_S;
        else
            tgt = PRIV_M;
    end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
    import trap_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit VECTORED_EN = 1'b1,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  priv_e             tgt,
    input  logic              is_nmi,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   m_tvec,
    input  logic [XLEN-1:0]   s_tvec,
    input  logic [XLEN-1:0]   u_tvec,
    input  logic [XLEN-1:0]   nmi_tvec,
    output logic [XLEN-1:0]   handler
);
    logic [XLEN-1:0] vec;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        case (tgt)
            PRIV_M:  vec = is_nmi ? nmi_tvec : m_tvec;
            PRIV_S:  vec = s_tvec;
            default: vec = u_tvec;
        endcase
        base = {vec[XLEN-1:2], 2'b00};
    end

    generate
        if (VECTORED_EN) begin : g_vec
            always_comb begin
                if (is_irq && (vec[1:0] == 2'b01))
                    offset = XLEN'({code, 2'b00});
                else
                    offset = '0;
            end
        end else begin : g_direct
            always_comb offset = '0;
        end
    endgenerate

    assign handler = base + offset;
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [LVL_W-1:0]                 wr_lvl,
    input  logic [XLEN-1:0]                  cause_in,
    input  logic [XLEN-1:0]                  epc_in,
    input  logic [XLEN-1:0]                  tval_in,
    output logic [NUM_LVL-1:0][XLEN-1:0]     cause_q,
    output logic [NUM_LVL-1:0][XLEN-1:0]     epc_q,
    output logic [NUM_LVL-1:0][XLEN-1:0]     tval_q
);
    generate
        for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
            logic hit;
            assign hit = wr_en && (wr_lvl == LVL_W'(i));
            always_ff @(posedge clk) begin
                if (rst) begin
                    cause_q[i] <= '0;
                    epc_q[i]   <= '0;
                    tval_q[i]  <= '0;
                end else if (hit) begin
                    cause_q[i] <= cause_in;
                    epc_q[i]   <= epc_in;
                    tval_q[i]  <= tval_in;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] RESET_VEC   = 'h1000,
    parameter bit              VECTORED_EN = 1'b1,
    localparam int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_valid,
    input  logic [1:0]        trap_class,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   trap_value,
    input  logic [STAT_W-1:0] cur_status,
    input  logic [XLEN-1:0]   m_ideleg,
    input  logic [XLEN-1:0]   m_edeleg,
    input  logic [XLEN-1:0]   s_ideleg,
    input  logic [XLEN-1:0]   s_edeleg,
    input  logic [XLEN-1:0]   m_tvec,
    input  logic [XLEN-1:0]   s_tvec,
    input  logic [XLEN-1:0]   u_tvec,
    input  logic [XLEN-1:0]   nmi_tvec,
    output logic [1:0]        priv_q,
    output logic [STAT_W-1:0] status_q,
    output logic              nmi_en_q,
    output logic [XLEN-1:0]   m_cause,
    output logic [XLEN-1:0]   m_epc,
    output logic [XLEN-1:0]   m_tval,
    output logic [XLEN-1:0]   s_cause,
    output logic [XLEN-1:0]   s_epc,
    output logic [XLEN-1:0]   s_tval,
    output logic [XLEN-1:0]   u_cause,
    output logic [XLEN-1:0]   u_epc,
    output logic [XLEN-1:0]   u_tval,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              resv_clear
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    trap_class_e      cls;
    priv_e            cur;
    priv_e            tgt;
    logic             is_nmi;
    logic             is_irq;
    logic [XLEN-1:0]  handler;
    logic [XLEN-1:0]  cause_val;
    logic [LVL_W-1:0] tgt_lvl;
    status_t          status_next;

    logic [NUM_LVL-1:0][XLEN-1:0] bank_cause;
    logic [NUM_LVL-1:0][XLEN-1:0] bank_epc;
    logic [NUM_LVL-1:0][XLEN-1:0] bank_tval;

    assign cls    = trap_class_e'(trap_class);
    assign cur    = priv_e'(cur_priv);
    assign is_nmi = (cls == TC_NMI);
    assign is_irq = class_is_irq(cls);

    trap_target_sel #(.XLEN(XLEN)) i_sel (
        .cls      (cls),
        .code     (trap_code),
        .cur      (cur),
        .m_ideleg (m_ideleg),
        .m_edeleg (m_edeleg),
        .s_ideleg (s_ideleg),
        .s_edeleg (s_edeleg),
        .tgt      (tgt)
    );

    trap_vector_calc #(.XLEN(XLEN), .VECTORED_EN(VECTORED_EN)) i_vec (
        .tgt      (tgt),
        .is_nmi   (is_nmi),
        .is_irq   (is_irq),
        .code     (trap_code),
        .m_tvec   (m_tvec),
        .s_tvec   (s_tvec),
        .u_tvec   (u_tvec),
        .nmi_tvec (nmi_tvec),
        .handler  (handler)
    );

    assign cause_val   = {is_irq, {PAD_W{1'b0}}, trap_code};
    assign tgt_lvl     = lvl_of(tgt);
    assign status_next = enter_status(status_t'(cur_status), tgt, cur);

    trap_csr_bank #(.XLEN(XLEN)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (trap_valid),
        .wr_lvl   (tgt_lvl),
        .cause_in (cause_val),
        .epc_in   (cur_pc),
        .tval_in  (trap_value),
        .cause_q  (bank_cause),
        .epc_q    (bank_epc),
        .tval_q   (bank_tval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q         <= PRIV_M;
            status_q       <= '0;
            nmi_en_q       <= 1'b1;
            redirect_valid <= 1'b0;
            resv_clear     <= 1'b0;
            redirect_pc    <= RESET_VEC;
        end else begin
            redirect_valid <= trap_valid;
            resv_clear     <= trap_valid;
            if (trap_valid) begin
                priv_q      <= tgt;
                status_q    <= status_next;
                redirect_pc <= handler;
                if (is_nmi)
                    nmi_en_q <= 1'b0;
            end
        end
    end

    assign m_cause = bank_cause[2];
    assign m_epc   = bank_epc[2];
    assign m_tval  = bank_tval[2];
    assign s_cause = bank_cause[1];
    assign s_epc   = bank_epc[1];
    assign s_tval  = bank_tval[1];
    assign u_cause = bank_cause[0];
    assign u_epc   = bank_epc[0];
    assign u_tval  = bank_tval[0];
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 'h1000
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_valid,
    input logic [1:0]      trap_class,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] cur_pc,
    input logic [1:0]      priv_q,
    input logic            nmi_en_q,
    input logic [XLEN-1:0] m_cause,
    input logic [XLEN-1:0] m_epc,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            resv_clear
);
    // R1: reset values
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (priv_q == 2'd3 && nmi_en_q && redirect_pc == RESET_VEC
                 && m_cause == '0 && !redirect_valid && !resv_clear));

    // R2: non-maskable interrupt lands in M and masks itself
    p_nmi_to_m_r2: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_class == 2'd2) |=> (priv_q == 2'd3 && !nmi_en_q));

    // R5: no downward delegation from M, EPC captured
    p_m_stays_m_r5: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == 2'd3) |=> (priv_q == 2'd3 && m_epc == $past(cur_pc)));

    // R7: exceptions never carry the interrupt flag
    p_exc_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_class == 2'd0 && cur_priv == 2'd3) |=> !m_cause[XLEN-1]);

    // R10: pulses follow a strobe
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (redirect_valid && resv_clear));

    // R10: quiet without a strobe
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> (!redirect_valid && !resv_clear && $stable(priv_q)
                         && $stable(redirect_pc) && $stable(m_cause)));
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) i_chk (.*);

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;
    localparam int CODE_W     = 5;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tv = 1'b0;
    logic [1:0] cls = '0;
    logic [CODE_W-1:0] code = '0;
    logic [1:0] cp = 2'd3;
    logic [31:0] pc = '0, val = '0;
    logic [17:0] cst = '0;
    logic [31:0] mid = '0, med = '0, sid = '0, sed = '0;
    logic [31:0] mvec = '0, svec = '0, uvec = '0, nvec = '0;

    logic [1:0] priv_q;
    logic [17:0] status_q;
    logic nmi_en_q, redirect_valid, resv_clear;
    logic [31:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval, u_cause, u_epc, u_tval, redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .RESET_VEC(RST_PC)) i_trap_entry_unit (
        .clk(clk), .rst(rst), .trap_valid(tv), .trap_class(cls), .trap_code(code),
        .cur_priv(cp), .cur_pc(pc), .trap_value(val), .cur_status(cst),
        .m_ideleg(mid), .m_edeleg(med), .s_ideleg(sid), .s_edeleg(sed),
        .m_tvec(mvec), .s_tvec(svec), .u_tvec(uvec), .nmi_tvec(nvec),
        .priv_q(priv_q), .status_q(status_q), .nmi_en_q(nmi_en_q),
        .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval),
        .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
        .u_cause(u_cause), .u_epc(u_epc), .u_tval(u_tval),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .resv_clear(resv_clear)
    );

    // reference model, updated on every rising edge
    logic [1:0]  e_priv;
    logic [17:0] e_stat;
    logic        e_nmi, e_rv;
    logic [31:0] e_pc;
    logic [31:0] e_cause [3];
    logic [31:0] e_epc [3];
    logic [31:0] e_tval [3];

    always @(posedge clk) begin
        if (rst) begin
            e_priv = 2'd3; e_stat = '0; e_nmi = 1'b1; e_rv = 1'b0; e_pc = RST_PC;
            for (int i = 0; i < 3; i++) begin e_cause[i] = '0; e_epc[i] = '0; e_tval[i] = '0; end
        end else begin
            e_rv = tv;
            if (tv) begin
                logic irq, nmi;
                logic [31:0] md, sd, vec, npc;
                logic [1:0] tgt;
                logic [17:0] st;
                int lv;
                irq = (cls != 2'd0);
                nmi = (cls == 2'd2);
                md = irq ? mid : med;
                sd = irq ? sid : sed;
                tgt = 2'd3;
                if (!nmi && cp != 2'd3 && md[code]) begin
                    tgt = 2'd1;
                    if (cp == 2'd0 && sd[code]) tgt = 2'd0;
                end
                st = cst;
                if (tgt == 2'd3) begin st[12:11] = cp; st[7] = st[3]; st[3] = 1'b0; end
                else if (tgt == 2'd1) begin st[8] = cp[0]; st[5] = st[1]; st[1] = 1'b0; end
                else begin st[4] = st[0]; st[0] = 1'b0; end
                if (tgt == 2'd3) vec = nmi ? nvec : mvec;
                else if (tgt == 2'd1) vec = svec;
                else vec = uvec;
                npc = {vec[31:2], 2'b00};
                if (irq && vec[1:0] == 2'b01) npc = npc + 32'(code) * 4;
                lv = (tgt == 2'd3) ? 2 : (tgt == 2'd1) ? 1 : 0;
                e_cause[lv] = {irq, 26'd0, code};
                e_epc[lv] = pc;
                e_tval[lv] = val;
                e_priv = tgt;
                e_stat = st;
                e_pc = npc;
                if (nmi) e_nmi = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(priv_q === e_priv, "R3", "priv", 32'(priv_q), 32'(e_priv));
        chk(status_q === e_stat, "R6", "status", 32'(status_q), 32'(e_stat));
        chk(nmi_en_q === e_nmi, "R2", "nmi_en", 32'(nmi_en_q), 32'(e_nmi));
        chk(m_cause === e_cause[2], "R7", "m_cause", m_cause, e_cause[2]);
        chk(s_cause === e_cause[1], "R7", "s_cause", s_cause, e_cause[1]);
        chk(u_cause === e_cause[0], "R7", "u_cause", u_cause, e_cause[0]);
        chk(m_epc === e_epc[2] && m_tval === e_tval[2], "R8", "m_epc/tval", m_epc, e_epc[2]);
        chk(s_epc === e_epc[1] && s_tval === e_tval[1], "R8", "s_epc/tval", s_epc, e_epc[1]);
        chk(u_epc === e_epc[0] && u_tval === e_tval[0], "R8", "u_epc/tval", u_epc, e_epc[0]);
        chk(redirect_pc === e_pc, "R9", "redirect_pc", redirect_pc, e_pc);
        chk(redirect_valid === e_rv, "R10", "redirect_valid", 32'(redirect_valid), 32'(e_rv));
        chk(resv_clear === e_rv, "R10", "resv_clear", 32'(resv_clear), 32'(e_rv));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_trap(input logic [1:0] c, input logic [CODE_W-1:0] k,
                           input logic [1:0] p, input logic [31:0] a, input logic [31:0] v);
        cls = c; code = k; cp = p; pc = a; val = v; tv = 1'b1;
        step();
        tv = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        chk(priv_q == 2'd3 && status_q == '0 && m_cause == '0 && nmi_en_q,
            "R1", "reset state", 32'(priv_q), 32'd3);
        chk(redirect_pc == RST_PC && !redirect_valid, "R1", "reset pc", redirect_pc, RST_PC);
        step();

        mid = 32'hFFFF_FFFF; sid = 32'hFFFF_FFFF;
        med = 32'h0000_0100; sed = 32'h0000_0100;
        mvec = 32'h8000_0001; svec = 32'h4000_0000;
        uvec = 32'h2000_0001; nvec = 32'h1000_0003;
        cst = 18'h3_FFFF;

        // R4: exception code 8 from U goes all the way to U, not vectored
        do_trap(2'd0, 5'd8, 2'd0, 32'h0000_0400, 32'hDEAD_0001);
        chk(priv_q == 2'd0, "R4", "exc to U", 32'(priv_q), 32'd0);
        chk(redirect_pc == 32'h2000_0000, "R9", "exc base only", redirect_pc, 32'h2000_0000);
        step();
        // R3: interrupt code 5 from U, vectored U handler
        do_trap(2'd1, 5'd5, 2'd0, 32'h0000_0500, 32'h0);
        chk(priv_q == 2'd0 && redirect_pc == 32'h2000_0014, "R3", "irq to U vectored",
            redirect_pc, 32'h2000_0014);
        // R3: interrupt from S goes to S
        cst = 18'h0_0AAA;
        do_trap(2'd1, 5'd7, 2'd1, 32'h0000_0600, 32'h0);
        chk(priv_q == 2'd1, "R3", "irq to S", 32'(priv_q), 32'd1);
        // R4: exception code 2 from S not delegated
        do_trap(2'd0, 5'd2, 2'd1, 32'h0000_0700, 32'h1234_5678);
        chk(priv_q == 2'd3 && redirect_pc == 32'h8000_0000, "R4", "exc to M",
            redirect_pc, 32'h8000_0000);
        // R5: interrupt from M with every bit delegated stays in M, vectored
        do_trap(2'd1, 5'd11, 2'd3, 32'h0000_0800, 32'h0);
        chk(priv_q == 2'd3 && redirect_pc == 32'h8000_002C, "R5", "M stays M",
            redirect_pc, 32'h8000_002C);
        // R2: NMI right behind the M trap (overlap), mode 3 vector not vectored
        cst = 18'h0_0000;
        do_trap(2'd2, 5'd3, 2'd3, 32'h8000_002C, 32'h0);
        chk(priv_q == 2'd3 && !nmi_en_q && redirect_pc == 32'h1000_0000, "R2", "nmi entry",
            redirect_pc, 32'h1000_0000);
        chk(m_cause == 32'h8000_0003 && m_epc == 32'h8000_002C, "R7", "nmi overwrites m_cause",
            m_cause, 32'h8000_0003);
        // R4: exception from U with only machine bit set goes to S
        sed = 32'h0;
        do_trap(2'd0, 5'd8, 2'd0, 32'h0000_0900, 32'h0);
        chk(priv_q == 2'd1 && status_q[8] == 1'b0, "R4", "exc stops at S", 32'(priv_q), 32'd1);
        // R3: interrupt from U with machine bit clear ignores supervisor bit
        mid = 32'h0;
        do_trap(2'd1, 5'd9, 2'd0, 32'h0000_0A00, 32'h0);
        chk(priv_q == 2'd3, "R3", "no S-only deleg", 32'(priv_q), 32'd3);
        // R10: idle cycles keep everything
        repeat (3) step();
        chk(!redirect_valid && !resv_clear, "R10", "idle", 32'(redirect_valid), 32'd0);
        // R11: reset and trap together
        rst = 1'b1;
        do_trap(2'd0, 5'd4, 2'd0, 32'h0000_0B00, 32'h0);
        rst = 1'b0;
        chk(!redirect_valid && redirect_pc == RST_PC && u_epc == '0 && priv_q == 2'd3,
            "R11", "reset wins", redirect_pc, RST_PC);
        step();

        // mixed stimulus
        for (int n = 0; n < 400; n++) begin
            logic [1:0] p;
            p = ($urandom_range(0, 2) == 2) ? 2'd3 : 2'($urandom_range(0, 1));
            mid = $urandom; med = $urandom; sid = $urandom; sed = $urandom;
            mvec = $urandom; svec = $urandom; uvec = $urandom; nvec = $urandom;
            cst = 18'($urandom);
            if ($urandom_range(0, 49) == 0) begin
                rst = 1'b1; step(); rst = 1'b0;
            end else if ($urandom_range(0, 3) == 0) begin
                step();
            end else begin
                do_trap(2'($urandom_range(0, 2)), 5'($urandom), p, $urandom, $urandom);
            end
        end
        step();
        finish_run();
    end
endmodule